// File: doc/BRIEF.md
# Segmented Address Translator

This block maps a short virtual address onto a physical address through a small segment table held in registers. The upper bits of the virtual address pick one of the segments. The lower bits are an offset into that segment. Each segment entry stores a physical base, a bound, three permission bits and a valid flag. In a single combinational pass, the block adds the offset to the base and, at the same time, compares the offset with the bound and tests the permission needed by the access type. The result is either a translated address or a fault with a cause code.

Software loads the table through a configuration write port. A write is accepted only while the privilege input is high. A write attempted without privilege leaves the table untouched and raises a one-cycle privilege-fault pulse. Reset marks every segment invalid.

Top module: `seg_xlate`

## Requirements
- R1: After reset every segment is invalid, so any access reports cause 2'b01 (bound violation) with `fault` high.
- R2: A legal access drives `pa` = segment base + zero-extended offset, truncated to `PA_BITS`, in the same cycle as the request (no register on the path). The segment is `va[VA_BITS-1:OFF_BITS]` and the offset is `va[OFF_BITS-1:0]`.
- R3: An access with offset greater than or equal to the segment bound reports cause 2'b01. Offset = bound-1 is legal. A bound of 2**OFF_BITS makes every offset legal.
- R4: An access to a segment whose valid bit is clear reports cause 2'b01.
- R5: Access codes are 2'b00 read, 2'b01 write and 2'b10 execute. Permission bits are bit0 read, bit1 write and bit2 execute. An access whose permission bit is clear reports cause 2'b10 (protection violation). Access code 2'b11 always reports 2'b10.
- R6: When an access breaks both the bound and the permission, the cause is 2'b01.
- R7: A configuration write with `cfg_priv` high replaces the entry selected by `cfg_seg` at the rising clock edge. Translations in the same cycle still use the old entry. Entries that are not selected keep their contents.
- R8: A configuration write with `cfg_priv` low leaves the table unchanged. It drives `priv_fault` high for exactly the one cycle after the edge that sampled the write. At all other times `priv_fault` is low.
- R9: `fault` is high exactly when `fault_cause` is not 2'b00. `pa` is zero whenever `fault` is high. Translation never reports cause 2'b11, which is reserved for the privilege pulse.
- R10: The four segments are independent. Each request is translated through the entry named by its own segment field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write request |
| cfg_priv | input | 1 | Privilege level of the requester (1 = privileged) |
| cfg_seg | input | SEG_BITS | Entry to write |
| cfg_base | input | PA_BITS | New base |
| cfg_bound | input | OFF_BITS+1 | New bound (limit on the offset, exclusive) |
| cfg_perm | input | 3 | New permissions: bit0 read, bit1 write, bit2 execute |
| cfg_valid | input | 1 | New valid flag |
| va | input | SEG_BITS+OFF_BITS | Virtual address |
| acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| pa | output | PA_BITS | Physical address, zero on fault |
| fault | output | 1 | Translation fault |
| fault_cause | output | 2 | 00 none, 01 bound, 10 protection |
| priv_fault | output | 1 | One-cycle pulse after an unprivileged write attempt |

## Verification
A translation result (`pa`, `fault`, `fault_cause`) is due in the same cycle as the request. The bench drives `va` and `acc` on the falling edge and samples one nanosecond later. Table writes and `priv_fault` change only at the rising edge. The bench therefore updates its reference table at that edge, then checks `priv_fault` and the translation that depends on the new entry after the next falling edge. Requests made in the same cycle as a write are checked against the old entry.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int unsigned PERM_W = 3;
   localparam int unsigned PERM_RD = 0;
   localparam int unsigned PERM_WR = 1;
   localparam int unsigned PERM_EX = 2;

   typedef enum logic [1:0] {
      ACC_READ  = 2'b00,
      ACC_WRITE = 2'b01,
      ACC_EXEC  = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'b00,
      CAUSE_BOUND = 2'b01,
      CAUSE_PROT  = 2'b10,
      CAUSE_PRIV  = 2'b11
   } cause_e;
endpackage

// File: rtl/seg_table.sv
module seg_table
   import seg_xlate_pkg::*;
#(
   parameter int unsigned SEG_BITS = 2,
   parameter int unsigned OFF_BITS = 12,
   parameter int unsigned PA_BITS  = 16,
   localparam int unsigned NUM_SEG = 1 << SEG_BITS,
   localparam int unsigned BND_W   = OFF_BITS + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                wr_priv,
   input  logic [SEG_BITS-1:0] wr_seg,
   input  logic [PA_BITS-1:0]  wr_base,
   input  logic [BND_W-1:0]    wr_bound,
   input  logic [PERM_W-1:0]   wr_perm,
   input  logic                wr_valid,
   output logic [PA_BITS-1:0]  ent_base  [NUM_SEG],
   output logic [BND_W-1:0]    ent_bound [NUM_SEG],
   output logic [PERM_W-1:0]   ent_perm  [NUM_SEG],
   output logic                ent_valid [NUM_SEG],
   output logic                denied
);
   logic accept;
   assign accept = wr_en & wr_priv;

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
      logic hit;
      assign hit = accept && (wr_seg == SEG_BITS'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_valid[g] <= 1'b0;
         end else if (hit) begin
            ent_valid[g] <= wr_valid;
         end
      end

      always_ff @(posedge clk) begin
         if (hit) begin
            ent_base[g]  <= wr_base;
            ent_bound[g] <= wr_bound;
            ent_perm[g]  <= wr_perm;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         denied <= 1'b0;
      end else begin
         denied <= wr_en & ~wr_priv;
      end
   end
endmodule

// File: rtl/seg_check.sv
module seg_check
   import seg_xlate_pkg::*;
#(
   parameter int unsigned OFF_BITS = 12,
   parameter int unsigned PA_BITS  = 16,
   localparam int unsigned BND_W   = OFF_BITS + 1
) (
   input  logic [OFF_BITS-1:0] off,
   input  logic [PA_BITS-1:0]  base,
   input  logic [BND_W-1:0]    bound,
   input  logic [PERM_W-1:0]   perm,
   input  logic                valid,
   input  logic [1:0]          acc,
   output logic [PA_BITS-1:0]  pa,
   output logic [1:0]          cause
);
   logic [PA_BITS-1:0] sum;
   logic               in_range;
   logic               perm_ok;

   // adder and comparator run side by side; neither waits on the other
   assign sum      = base + PA_BITS'(off);
   assign in_range = valid && ({1'b0, off} < bound);

   always_comb begin
      unique case (acc_e'(acc))
         ACC_READ:  perm_ok = perm[PERM_RD];
         ACC_WRITE: perm_ok = perm[PERM_WR];
         ACC_EXEC:  perm_ok = perm[PERM_EX];
         default:   perm_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!in_range) begin
         cause = CAUSE_BOUND;
      end else if (!perm_ok) begin
         cause = CAUSE_PROT;
      end else begin
         cause = CAUSE_NONE;
      end
   end

   assign pa = (cause == CAUSE_NONE) ? sum : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int unsigned SEG_BITS = 2,
   parameter int unsigned OFF_BITS = 12,
   parameter int unsigned PA_BITS  = 16,
   localparam int unsigned NUM_SEG = 1 << SEG_BITS,
   localparam int unsigned VA_BITS = SEG_BITS + OFF_BITS,
   localparam int unsigned BND_W   = OFF_BITS + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic                cfg_priv,
   input  logic [SEG_BITS-1:0] cfg_seg,
   input  logic [PA_BITS-1:0]  cfg_base,
   input  logic [BND_W-1:0]    cfg_bound,
   input  logic [2:0]          cfg_perm,
   input  logic                cfg_valid,
   input  logic [VA_BITS-1:0]  va,
   input  logic [1:0]          acc,
   output logic [PA_BITS-1:0]  pa,
   output logic                fault,
   output logic [1:0]          fault_cause,
   output logic                priv_fault
);
   if (SEG_BITS < 1 || SEG_BITS > 6) begin : g_bad_seg
      $error("seg_xlate: SEG_BITS out of range");
   end
   if (OFF_BITS < 1 || PA_BITS < OFF_BITS) begin : g_bad_width
      $error("seg_xlate: PA_BITS must cover OFF_BITS");
   end

   logic [PA_BITS-1:0] t_base  [NUM_SEG];
   logic [BND_W-1:0]   t_bound [NUM_SEG];
   logic [PERM_W-1:0]  t_perm  [NUM_SEG];
   logic               t_valid [NUM_SEG];

   seg_table #(
      .SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)
   ) i_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_priv(cfg_priv), .wr_seg(cfg_seg),
      .wr_base(cfg_base), .wr_bound(cfg_bound), .wr_perm(cfg_perm),
      .wr_valid(cfg_valid),
      .ent_base(t_base), .ent_bound(t_bound), .ent_perm(t_perm),
      .ent_valid(t_valid),
      .denied(priv_fault)
   );

   logic [SEG_BITS-1:0] sel;
   logic [OFF_BITS-1:0] off;
   assign sel = va[VA_BITS-1:OFF_BITS];
   assign off = va[OFF_BITS-1:0];

   logic [1:0] cause;

   seg_check #(
      .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)
   ) i_check (
      .off(off),
      .base(t_base[sel]), .bound(t_bound[sel]),
      .perm(t_perm[sel]), .valid(t_valid[sel]),
      .acc(acc),
      .pa(pa), .cause(cause)
   );

   assign fault_cause = cause;
   assign fault       = |cause;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int unsigned SEG_BITS = 2,
   parameter int unsigned OFF_BITS = 12,
   parameter int unsigned PA_BITS  = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_we,
   input logic                         cfg_priv,
   input logic [SEG_BITS+OFF_BITS-1:0] va,
   input logic [PA_BITS-1:0]           pa,
   input logic                         fault,
   input logic [1:0]                   fault_cause,
   input logic                         priv_fault
);
   AST_PA_ZERO_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (pa == '0)); // R9
   AST_NO_PRIV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_cause != 2'b11); // R9
   AST_PRIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_priv) |=> priv_fault); // R8
   AST_PRIV_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |-> $past(cfg_we && !cfg_priv)); // R8
   AST_PRIV_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || cfg_priv) |=> !priv_fault); // R8
endmodule

bind seg_xlate seg_xlate_chk #(
   .SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
   .va(va), .pa(pa), .fault(fault), .fault_cause(fault_cause),
   .priv_fault(priv_fault)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0;
   logic [1:0]  cfg_seg = '0;
   logic [15:0] cfg_base = '0;
   logic [12:0] cfg_bound = '0;
   logic [2:0]  cfg_perm = '0;
   logic [13:0] va = '0;
   logic [1:0]  acc = '0;
   logic [15:0] pa;
   logic        fault;
   logic [1:0]  fault_cause;
   logic        priv_fault;

   int checks = 0;
   int errors = 0;
   logic exp_pf = 1'b0;

   logic [15:0] m_base  [4];
   logic [12:0] m_bound [4];
   logic [2:0]  m_perm  [4];
   logic        m_valid [4];

   always #2.5 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
      .cfg_seg(cfg_seg), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
      .cfg_perm(cfg_perm), .cfg_valid(cfg_valid), .va(va), .acc(acc),
      .pa(pa), .fault(fault), .fault_cause(fault_cause),
      .priv_fault(priv_fault)
   );

   task automatic check(input logic ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [17:0] expect_xl(input logic [13:0] v, input logic [1:0] a);
      logic [1:0]  s;
      logic [11:0] o;
      logic        ok;
      s = v[13:12];
      o = v[11:0];
      if (!m_valid[s] || {1'b0, o} >= m_bound[s]) return {2'b01, 16'h0};
      case (a)
         2'd0: ok = m_perm[s][0];
         2'd1: ok = m_perm[s][1];
         2'd2: ok = m_perm[s][2];
         default: ok = 1'b0;
      endcase
      if (!ok) return {2'b10, 16'h0};
      return {2'b00, m_base[s] + {4'h0, o}};
   endfunction

   // one cycle: drive at falling edge, check 1 ns later, model follows rising edge
   task automatic step(input logic we, input logic pv, input logic [1:0] sg,
                       input logic [15:0] b, input logic [12:0] bd,
                       input logic [2:0] pm, input logic vl,
                       input logic [13:0] v, input logic [1:0] a, input string tag);
      logic [17:0] e;
      @(negedge clk);
      cfg_we = we; cfg_priv = pv; cfg_seg = sg; cfg_base = b;
      cfg_bound = bd; cfg_perm = pm; cfg_valid = vl; va = v; acc = a;
      #1;
      check(priv_fault == exp_pf, "R8 priv_fault", 32'(priv_fault), 32'(exp_pf));
      e = expect_xl(v, a);
      check(fault_cause == e[17:16], {tag, " cause"}, 32'(fault_cause), 32'(e[17:16]));
      check(pa == e[15:0], {tag, " pa"}, 32'(pa), 32'(e[15:0]));
      check(fault == (e[17:16] != 2'b00), "R9 fault flag", 32'(fault), 32'(e[17:16] != 0));
      @(posedge clk);
      if (we && pv) begin
         m_base[sg] = b; m_bound[sg] = bd; m_perm[sg] = pm; m_valid[sg] = vl;
      end
      exp_pf = we && !pv;
   endtask

   task automatic look(input logic [13:0] v, input logic [1:0] a, input string tag);
      step(1'b0, 1'b0, 2'd0, 16'h0, 13'h0, 3'h0, 1'b0, v, a, tag);
   endtask

   task automatic wr(input logic pv, input logic [1:0] sg, input logic [15:0] b,
                     input logic [12:0] bd, input logic [2:0] pm, input logic vl);
      step(1'b1, pv, sg, b, bd, pm, vl, 14'h0, 2'd0, "R7 write cycle");
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_base[i] = '0; m_bound[i] = '0; m_perm[i] = '0; m_valid[i] = 1'b0;
      end
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: all invalid after reset
      for (int s = 0; s < 4; s++) look({2'(s), 12'h000}, 2'd0, "R1 reset invalid");

      // R7: write seg1 (perm read+write), check same-cycle old view then new
      step(1'b1, 1'b1, 2'd1, 16'h1000, 13'h100, 3'b011, 1'b1,
           14'h1010, 2'd0, "R7 old entry same cycle");
      look(14'h10FF, 2'd0, "R2 legal read");
      look(14'h1100, 2'd1, "R3 offset equals bound");
      look(14'h10FF, 2'd1, "R3 offset bound-1 legal");
      look(14'h1005, 2'd2, "R5 exec denied");
      look(14'h1005, 2'd3, "R5 reserved access");
      // R6: out of range and no permission gives bound
      look(14'h1200, 2'd2, "R6 bound before protection");
      // R4: invalid segment with bound and perms set
      wr(1'b1, 2'd2, 16'h2000, 13'h1000, 3'b111, 1'b0);
      look(14'h2001, 2'd0, "R4 invalid segment");
      // R3 full bound, wraparound of pa
      wr(1'b1, 2'd3, 16'hF800, 13'h1000, 3'b100, 1'b1);
      look(14'h3FFF, 2'd2, "R3 full bound top offset");
      look(14'h3FFF, 2'd0, "R5 read denied");
      // R8: unprivileged write ignored, pulse one cycle
      wr(1'b0, 2'd1, 16'h7777, 13'h1000, 3'b111, 1'b1);
      look(14'h1200, 2'd2, "R8 table unchanged after denied write");
      look(14'h1020, 2'd1, "R8 entry kept");
      // R10: each segment distinct
      wr(1'b1, 2'd0, 16'h0400, 13'h0800, 3'b001, 1'b1);
      for (int s = 0; s < 4; s++) look({2'(s), 12'h044}, 2'd0, "R10 per segment");

      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic we, pv, vl;
         logic [12:0] bd;
         we = ($urandom % 4) == 0;
         pv = ($urandom % 4) != 0;
         vl = ($urandom % 6) != 0;
         bd = ($urandom % 3 == 0) ? 13'(($urandom % 64)) : 13'(($urandom % 4097));
         step(we, pv, 2'($urandom), 16'($urandom), bd, 3'($urandom), vl,
              14'($urandom), 2'($urandom % 4), "R2/R3/R5 random");
      end

      look(14'h0, 2'd0, "R8 final pulse");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule